// File: doc/BRIEF.md
# NRZ Transmit Byte Serializer

This block turns bytes handed over by a host into a serial non-return-to-zero level stream for a downstream sub-audio output filter. The host writes a byte into a one-byte holding buffer whenever the buffer reports that it has room. The serializer moves the held byte into a shift register and sends it most significant bit first. Each bit lasts a number of clock cycles chosen by a baud select input.

A byte that is waiting in the buffer when the current byte ends follows on with no gap, so a host that refills the buffer promptly gets a continuous stream. Two status levels tell the host what to do next. One says the buffer can take another byte. The other says the last byte has fully left the shift register and nothing is queued behind it.

When the block is enabled but has nothing to send, it lowers an output-active qualifier, and the downstream stage reads that as "hold the line at bias" rather than as a logic level. Disabling the block or putting it into power-down has the same effect at once.

Top module: `nrz_tx_serializer`

## Requirements
- R1: After reset, tx_active and tx_bit are 0, buf_ready is 1 and tx_done is 0.
- R2: A write (wr_valid high) is accepted only while buf_ready is 1. buf_ready then reads 0 from the next cycle until the byte is moved into the shift register. A write made while buf_ready is 0 is ignored: its data is never sent.
- R3: Each byte is sent most significant bit first. Every bit is held on tx_bit for exactly BASE_DIV << baud_sel clock cycles, which gives 4, 8, 16 or 32 cycles for baud_sel 0 to 3 with the default BASE_DIV of 4.
- R4: While the block is running and the shifter is idle, a byte accepted at clock edge E is loaded at edge E+1. From that edge tx_active is 1, tx_bit carries the byte's bit 7, and buf_ready is 1 again.
- R5: If the buffer holds a byte when the last bit of the current byte ends, that byte's bit 7 appears in the very next cycle and tx_active stays 1 throughout.
- R6: When the last bit of a byte ends while the buffer is empty, tx_active falls and tx_done becomes 1 in the same cycle. tx_done stays 1 until the next accepted write clears it. If a write is accepted in that same cycle, tx_done stays 0.
- R7: Whenever no byte is being shifted, tx_active is 0 (bias) and tx_bit is 0.
- R8: The block runs only while enable is 1 and powerdown is 0. In any other case tx_active is 0 in the same cycle, any byte in progress is dropped without setting tx_done, and a byte already in the buffer is kept and sent once the block runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Encoder enable |
| powerdown | input | 1 | Full power-down; forces bias output |
| baud_sel | input | SEL_W | Bit period select, period = BASE_DIV << baud_sel cycles |
| wr_valid | input | 1 | Host write strobe for the holding buffer |
| wr_data | input | BYTE_W | Byte to transmit |
| tx_bit | output | 1 | Serial NRZ data level, meaningful while tx_active is 1 |
| tx_active | output | 1 | 1 = tx_bit is a data level, 0 = hold output at bias |
| buf_ready | output | 1 | Holding buffer can accept a byte |
| tx_done | output | 1 | Last byte fully shifted out with nothing queued |

## Verification
The assertions assume that the host writes only when buf_ready is 1, or that ignored writes are harmless. They also assume that baud_sel does not change while a byte is being shifted, because the bit timer compares against the live selection. The stimulus changes baud_sel only while the serializer is idle, between streams. The host write for the next byte is issued as soon as buf_ready returns, which is far earlier than the end of the current byte at every baud rate. The same-cycle write and done race is therefore never driven. The stimulus does make deliberate writes while buf_ready is 0, and it switches enable and powerdown in the middle of a byte to reach the drop and keep cases.

// File: rtl/nrz_tx_pkg.sv
// Package: shared constants and helpers for the NRZ transmit serializer.
// Assumes: byte width of 8 is the only width the host side uses.
package nrz_tx_pkg;

    localparam int unsigned BYTE_BITS = 8;

    // Bit period in clock cycles for a given base divider and selection.
    function automatic int unsigned bit_period(input int unsigned base_div,
                                               input int unsigned sel);
        return base_div << sel;
    endfunction

endpackage

// File: rtl/nrz_baud_timer.sv
// Module: bit-period timer. Counts clock cycles inside one bit and raises
// bit_end on the last cycle of the bit.
// Assumes: sel is stable while active is high; clear forces the count to 0.
module nrz_baud_timer #(
    parameter int unsigned BASE_DIV = 4,
    parameter int unsigned SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             clear,
    input  logic [SEL_W-1:0] sel,
    output logic             bit_end
);
    localparam int unsigned MAX_PERIOD = nrz_tx_pkg::bit_period(BASE_DIV, (1 << SEL_W) - 1);
    localparam int unsigned CW         = $clog2(MAX_PERIOD) + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] period;

    // Current bit length for the selected rate.
    always_comb begin
        period = CW'(BASE_DIV) << sel;
    end

    // Last cycle of the bit is reached when the count hits period-1.
    always_comb begin
        bit_end = active && (cnt_q == period - CW'(1));
    end

    // Cycle counter inside one bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || bit_end) begin
            cnt_q <= '0;
        end else if (active) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/nrz_tx_holdbuf.sv
// Module: one-byte holding buffer between host and shifter.
// Assumes: take is only raised while full is high, so a write and a take
// never meet in the same cycle.
module nrz_tx_holdbuf #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [BYTE_W-1:0] data
);
    logic              full_q;
    logic [BYTE_W-1:0] data_q;
    logic              accept;

    // A write lands only in an empty buffer.
    always_comb begin
        accept = wr_valid && !full_q;
    end

    // Occupancy flag and stored byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (take) begin
            full_q <= 1'b0;
        end else if (accept) begin
            full_q <= 1'b1;
            data_q <= wr_data;
        end
    end

    assign full = full_q;
    assign data = data_q;
endmodule

// File: rtl/nrz_tx_shifter.sv
// Module: byte shift engine. Loads from the holding buffer, shifts MSB first
// on each bit end, reloads back-to-back, and reports byte completion.
// Assumes: bit_end comes from a timer gated by this module's busy output and
// run.
module nrz_tx_shifter #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              buf_full,
    input  logic [BYTE_W-1:0] buf_data,
    input  logic              bit_end,
    output logic              take,
    output logic              busy,
    output logic              msb,
    output logic              done_set
);
    localparam int unsigned BCW = $clog2(BYTE_W);

    logic              busy_q;
    logic [BYTE_W-1:0] shreg_q;
    logic [BCW-1:0]    bcnt_q;
    logic              last_bit;

    // Final bit of the byte is on the line.
    always_comb begin
        last_bit = (bcnt_q == BCW'(BYTE_W - 1));
    end

    // Load when idle, or at the end of the final bit, if a byte is waiting.
    always_comb begin
        take = run && buf_full && (!busy_q || (bit_end && last_bit));
    end

    // Byte finished with nothing queued behind it.
    always_comb begin
        done_set = run && busy_q && bit_end && last_bit && !buf_full;
    end

    // Shift register, bit counter and busy state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            shreg_q <= '0;
            bcnt_q  <= '0;
        end else if (!run) begin
            busy_q <= 1'b0;
            bcnt_q <= '0;
        end else if (take) begin
            busy_q  <= 1'b1;
            shreg_q <= buf_data;
            bcnt_q  <= '0;
        end else if (busy_q && bit_end) begin
            if (last_bit) begin
                busy_q <= 1'b0;
            end else begin
                shreg_q <= shreg_q << 1;
                bcnt_q  <= bcnt_q + BCW'(1);
            end
        end
    end

    assign busy = busy_q;
    assign msb  = shreg_q[BYTE_W-1];
endmodule

// File: rtl/nrz_tx_serializer.sv
// Module: top of the NRZ transmit serializer. Ties the holding buffer, shift
// engine and bit timer together and produces the status levels.
// Assumes: baud_sel is changed only while tx_active is low.
module nrz_tx_serializer #(
    parameter int unsigned BASE_DIV = 4,
    parameter int unsigned SEL_W    = 2,
    parameter int unsigned BYTE_W   = nrz_tx_pkg::BYTE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              powerdown,
    input  logic [SEL_W-1:0]  baud_sel,
    input  logic              wr_valid,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              tx_bit,
    output logic              tx_active,
    output logic              buf_ready,
    output logic              tx_done
);
    logic              run;
    logic              buf_full;
    logic [BYTE_W-1:0] buf_data;
    logic              take;
    logic              busy;
    logic              msb;
    logic              done_set;
    logic              bit_end;
    logic              accepted;
    logic              done_q;

    // Block runs only when enabled and not powered down.
    always_comb begin
        run      = enable && !powerdown;
        accepted = wr_valid && !buf_full;
    end

    nrz_tx_holdbuf #(.BYTE_W(BYTE_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .take     (take),
        .full     (buf_full),
        .data     (buf_data)
    );

    nrz_tx_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .buf_full (buf_full),
        .buf_data (buf_data),
        .bit_end  (bit_end),
        .take     (take),
        .busy     (busy),
        .msb      (msb),
        .done_set (done_set)
    );

    nrz_baud_timer #(.BASE_DIV(BASE_DIV), .SEL_W(SEL_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (busy && run),
        .clear   (!busy || !run),
        .sel     (baud_sel),
        .bit_end (bit_end)
    );

    // Transmission-complete level: set on an empty finish, cleared by a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (accepted) begin
            done_q <= 1'b0;
        end else if (done_set) begin
            done_q <= 1'b1;
        end
    end

    // Output qualifier and level; low level while at bias.
    always_comb begin
        tx_active = busy && run;
        tx_bit    = tx_active && msb;
        buf_ready = !buf_full;
        tx_done   = done_q;
    end
endmodule

// File: rtl/nrz_tx_checker.sv
// Module: assertion checker for the NRZ transmit serializer, bound to the top.
// Assumes: baud_sel is held steady during a byte.
module nrz_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic powerdown,
    input logic wr_valid,
    input logic tx_bit,
    input logic tx_active,
    input logic buf_ready,
    input logic tx_done
);
    // R7: at bias the data level is low.
    a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> !tx_bit);

    // R2: an accepted write fills the buffer.
    a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && buf_ready) |=> !buf_ready);

    // R8: not running means bias.
    a_r8_off_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable || powerdown) |-> !tx_active);

    // R4: shifting starts only from a filled buffer.
    a_r4_start_needs_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_active) |-> $past(!buf_ready));

    // R6: completion implies idle.
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> !tx_active);

    // R6: completion rises only with an empty buffer after a byte was sent.
    a_r6_done_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> (buf_ready && $past(tx_active)));
endmodule

bind nrz_tx_serializer nrz_tx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .powerdown (powerdown),
    .wr_valid  (wr_valid),
    .tx_bit    (tx_bit),
    .tx_active (tx_active),
    .buf_ready (buf_ready),
    .tx_done   (tx_done)
);

// File: tb/tb_nrz_tx_serializer.sv
module tb_nrz_tx_serializer;
    localparam int BASE = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       powerdown = 1'b0;
    logic [1:0] baud_sel = 2'd0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tx_bit, tx_active, buf_ready, tx_done;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] bytes [3];

    always #2 clk = ~clk;

    nrz_tx_serializer dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .powerdown(powerdown),
        .baud_sel(baud_sel), .wr_valid(wr_valid), .wr_data(wr_data),
        .tx_bit(tx_bit), .tx_active(tx_active), .buf_ready(buf_ready),
        .tx_done(tx_done)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Sends n bytes at the given rate; preload means byte 0 already sits in
    // the buffer with enable low.
    task automatic stream(input int n, input int sel, input bit preload);
        int p = BASE << sel;
        int sent = 1;
        @(negedge clk);
        baud_sel = 2'(sel);
        if (preload) begin
            enable = 1'b1;
        end else begin
            wr_data = bytes[0];
            wr_valid = 1'b1;
            @(negedge clk);
            wr_valid = 1'b0;
            check("R2 buf_ready after write", int'(buf_ready), 0);
            check("R4 idle before load", int'(tx_active), 0);
            check("R6 done cleared by write", int'(tx_done), 0);
        end
        @(negedge clk);
        check("R4 buf_ready after load", int'(buf_ready), 1);
        for (int k = 0; k < n * 8 * p; k++) begin
            int bi = k / (8 * p);
            int bp = 7 - ((k / p) % 8);
            if (k > 0) @(negedge clk);
            wr_valid = 1'b0;
            check("R5 active during stream", int'(tx_active), 1);
            check("R3 bit level", int'(tx_bit), int'(bytes[bi][bp]));
            check("R6 done low while sending", int'(tx_done), 0);
            if (buf_ready && sent < n && !wr_valid) begin
                wr_data = bytes[sent];
                wr_valid = 1'b1;
                sent++;
            end
        end
        @(negedge clk);
        wr_valid = 1'b0;
        check("R6 active low at end", int'(tx_active), 0);
        check("R6 done at end", int'(tx_done), 1);
        check("R7 bit low at bias", int'(tx_bit), 0);
        check("R2 buffer empty at end", int'(buf_ready), 1);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 tx_active", int'(tx_active), 0);
        check("R1 tx_bit", int'(tx_bit), 0);
        check("R1 buf_ready", int'(buf_ready), 1);
        check("R1 tx_done", int'(tx_done), 0);

        // R7 enabled but idle sits at bias
        enable = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 idle enabled", int'(tx_active), 0);

        // R3/R4/R5/R6 sweep over rates and stream lengths
        for (int sel = 0; sel < 4; sel++) begin
            for (int n = 1; n <= 3; n++) begin
                for (int j = 0; j < 3; j++)
                    bytes[j] = 8'(8'hA5 ^ (sel * 37 + n * 13 + j * 91));
                stream(n, sel, 1'b0);
            end
        end

        // R2/R8 buffered byte kept while disabled; a write while full is ignored
        @(negedge clk);
        enable = 1'b0;
        wr_data = 8'h3C;
        wr_valid = 1'b1;
        @(negedge clk);
        wr_data = 8'hC3;
        @(negedge clk);
        wr_valid = 1'b0;
        repeat (4) @(negedge clk);
        check("R8 disabled stays at bias", int'(tx_active), 0);
        check("R2 buffer still full", int'(buf_ready), 0);
        bytes[0] = 8'h3C;
        stream(1, 1, 1'b1);

        // R8 power-down mid-byte drops the byte without completion
        bytes[0] = 8'hF0;
        @(negedge clk);
        wr_data = 8'hF0;
        wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        repeat (6) @(negedge clk);
        check("R8 sending before power-down", int'(tx_active), 1);
        powerdown = 1'b1;
        #1;
        check("R8 power-down immediate bias", int'(tx_active), 0);
        check("R7 bit low in power-down", int'(tx_bit), 0);
        repeat (5) @(negedge clk);
        check("R8 no done after drop", int'(tx_done), 0);
        powerdown = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 stays idle after drop", int'(tx_active), 0);
        check("R8 buffer empty after drop", int'(buf_ready), 1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule